// File: doc/BRIEF.md
# Reservation Monitor for Conditional Stores

This block sits beside a shared memory and keeps one address reservation for each requesting context. A requester opens a reservation with a reserving load. It later tries a conditional store to the same location. The block decides whether that conditional store may update memory. It sees one request per cycle, described by a context number, a physical address and three qualifiers: read, write and conditional.

Addresses are reduced to an aligned granule before they are stored or compared. Any write that goes ahead removes every reservation held on its granule, whatever context holds it. Each context that loses a reservation this way receives a one-cycle wake-up pulse. This lets a requester sleeping on a lock resume. A conditional store that fails changes no reservation. The verdict for every write comes back one cycle after the request on a registered valid/pass pair.

Top module: `lrsc_monitor`

## Requirements
- R1: After reset no context holds a reservation, and `rsp_valid` and `wake` are low. A conditional store issued straight after reset fails and pulses no wake-up.
- R2: Address bits below `GRAN_LSB` (default 3, an 8-byte granule) are ignored when a reservation is stored or compared. Addresses 0x200 and 0x204 therefore fall in one granule.
- R3: A reserving load (`req_read`=1, `req_cond`=1, `req_write`=0) from a context with no reservation creates one. A conditional store from that context to that granule then passes.
- R4: A reserving load from a context that already holds a reservation replaces the stored granule. A later conditional store to the old granule fails, and one to the new granule passes.
- R5: Every write (`req_write`=1) gets exactly one result, with `rsp_valid` high in the cycle after the request. On that cycle `rsp_pass` is 1 for success and 0 for failure. A conditional store (`req_cond`=1) passes only if its own context holds a reservation on its granule. A reservation held by another context on the same granule does not count.
- R6: An ordinary store (`req_write`=1, `req_cond`=0) always passes.
- R7: A passing write clears the reservation of every context on the written granule. In the same cycle as `rsp_valid`, it raises `wake` bit i for each cleared context i, and only for those.
- R8: A failing conditional store clears no reservation and leaves `wake` at zero.
- R9: A plain read (`req_cond`=0, `req_write`=0) produces no response and leaves reservations as they were. A request with both read and write set is handled as a write.
- R10: A write leaves reservations on other granules intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_ctx | input | CTX_W | Requesting context number |
| req_addr | input | ADDR_W | Physical byte address |
| req_read | input | 1 | Request is a load |
| req_write | input | 1 | Request is a store |
| req_cond | input | 1 | Reserving load or conditional store |
| rsp_valid | output | 1 | Write verdict available |
| rsp_pass | output | 1 | 1 = write proceeds, 0 = conditional store failed |
| wake | output | NUM_CTX | One-cycle pulse per context whose reservation was cleared |

## Verification
The bound checker watches properties that hold on every cycle. It checks that a result appears exactly after each write and never after a plain read. It checks that ordinary stores always pass and that a wake-up occurs only with a passing result. It also checks that a passing conditional store wakes its own context. Reservation state is not visible at the ports, so the directed scenarios must show it. They cover replacement of a reservation, granule masking, survival of reservations on other granules, and the rule that another context's reservation does not help a conditional store.

// File: rtl/lrsc_pkg.sv
package lrsc_pkg;

    typedef enum logic [1:0] {
        OP_IDLE,
        OP_LOAD_RSV,
        OP_STORE_PLAIN,
        OP_STORE_COND
    } lrsc_op_e;

    // Write has precedence over read when both qualifiers are set.
    function automatic lrsc_op_e lrsc_decode(input logic vld, input logic rd,
                                             input logic wr, input logic cnd);
        lrsc_op_e op;
        op = OP_IDLE;
        if (vld) begin
            if (wr)
                op = cnd ? OP_STORE_COND : OP_STORE_PLAIN;
            else if (rd && cnd)
                op = OP_LOAD_RSV;
        end
        return op;
    endfunction

    function automatic logic lrsc_is_store(input lrsc_op_e op);
        return (op == OP_STORE_PLAIN) || (op == OP_STORE_COND);
    endfunction

endpackage

// File: rtl/lrsc_slot.sv
module lrsc_slot #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_en,
    input  logic              clear_en,
    input  logic [ADDR_W-1:0] gran_addr,
    output logic              hit
);
    logic              held_q;
    logic [ADDR_W-1:0] addr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            held_q <= 1'b0;
            addr_q <= '0;
        end else if (load_en) begin
            held_q <= 1'b1;
            addr_q <= gran_addr;
        end else if (clear_en) begin
            held_q <= 1'b0;
        end
    end

    assign hit = held_q && (addr_q == gran_addr);
endmodule

// File: rtl/lrsc_monitor.sv
module lrsc_monitor #(
    parameter int NUM_CTX  = 4,
    parameter int ADDR_W   = 32,
    parameter int GRAN_LSB = 3,
    localparam int CTX_W   = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    input  logic [CTX_W-1:0]   req_ctx,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic               req_read,
    input  logic               req_write,
    input  logic               req_cond,
    output logic               rsp_valid,
    output logic               rsp_pass,
    output logic [NUM_CTX-1:0] wake
);
    import lrsc_pkg::*;

    localparam logic [ADDR_W-1:0] GRAN_MASK = ~((ADDR_W'(1) << GRAN_LSB) - ADDR_W'(1));

    lrsc_op_e           op;
    logic [ADDR_W-1:0]  gran;
    logic [NUM_CTX-1:0] hit_vec;
    logic [NUM_CTX-1:0] clr_vec;
    logic               own_hit;
    logic               pass_c;
    logic               store_c;

    assign op      = lrsc_decode(req_valid, req_read, req_write, req_cond);
    assign gran    = req_addr & GRAN_MASK;
    assign store_c = lrsc_is_store(op);
    assign own_hit = hit_vec[req_ctx];
    assign pass_c  = (op == OP_STORE_COND) ? own_hit : 1'b1;
    assign clr_vec = (store_c && pass_c) ? hit_vec : '0;

    for (genvar i = 0; i < NUM_CTX; i++) begin : g_slot
        lrsc_slot #(.ADDR_W(ADDR_W)) u_slot (
            .clk      (clk),
            .rst      (rst),
            .load_en  ((op == OP_LOAD_RSV) && (req_ctx == CTX_W'(i))),
            .clear_en (clr_vec[i]),
            .gran_addr(gran),
            .hit      (hit_vec[i])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_pass  <= 1'b0;
            wake      <= '0;
        end else begin
            rsp_valid <= store_c;
            rsp_pass  <= store_c && pass_c;
            wake      <= clr_vec;
        end
    end
endmodule

// File: rtl/lrsc_monitor_chk.sv
module lrsc_monitor_chk #(
    parameter int NUM_CTX = 4,
    parameter int CTX_W   = 2
) (
    input logic               clk,
    input logic               rst,
    input logic               req_valid,
    input logic [CTX_W-1:0]   req_ctx,
    input logic               req_read,
    input logic               req_write,
    input logic               req_cond,
    input logic               rsp_valid,
    input logic               rsp_pass,
    input logic [NUM_CTX-1:0] wake
);
    // R5: one result exactly in the cycle after each write
    p_result_follows_write_r5: assert property (@(posedge clk) disable iff (rst)
        $past(req_valid && req_write) |-> rsp_valid);
    p_result_only_for_write_r5: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $past(req_valid && req_write));
    // R6: ordinary store never fails
    p_plain_store_passes_r6: assert property (@(posedge clk) disable iff (rst)
        $past(req_valid && req_write && !req_cond) |-> rsp_pass);
    // R8: no wake-up without a passing result
    p_no_wake_on_fail_r8: assert property (@(posedge clk) disable iff (rst)
        (wake != '0) |-> (rsp_valid && rsp_pass));
    // R7: passing conditional store clears its own reservation
    p_cond_wakes_self_r7: assert property (@(posedge clk) disable iff (rst)
        ($past(req_valid && req_write && req_cond) && rsp_pass) |-> wake[$past(req_ctx)]);
    // R9: plain read gives no response
    p_read_silent_r9: assert property (@(posedge clk) disable iff (rst)
        $past(req_valid && req_read && !req_write) |-> !rsp_valid);
    // R1: outputs idle in the first cycle after reset
    p_reset_idle_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!rsp_valid && wake == '0));
endmodule

bind lrsc_monitor lrsc_monitor_chk #(.NUM_CTX(NUM_CTX), .CTX_W(CTX_W)) u_chk (.*);

// File: tb/sim_lrsc_monitor.sv
module sim_lrsc_monitor;
    localparam int NUM_CTX = 4;
    localparam int ADDR_W  = 32;
    localparam int CTX_W   = 2;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               req_valid = 1'b0;
    logic [CTX_W-1:0]   req_ctx = '0;
    logic [ADDR_W-1:0]  req_addr = '0;
    logic               req_read = 1'b0;
    logic               req_write = 1'b0;
    logic               req_cond = 1'b0;
    logic               rsp_valid;
    logic               rsp_pass;
    logic [NUM_CTX-1:0] wake;

    int checks = 0;
    int errors = 0;
    logic               got_v, got_p;
    logic [NUM_CTX-1:0] got_w;

    always #4 clk = ~clk;

    lrsc_monitor #(.NUM_CTX(NUM_CTX), .ADDR_W(ADDR_W), .GRAN_LSB(3)) u0 (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic issue(input int ctx, input logic [31:0] a, input logic rd,
                         input logic wr, input logic cn);
        @(negedge clk);
        req_valid = 1'b1; req_ctx = CTX_W'(ctx); req_addr = a;
        req_read = rd; req_write = wr; req_cond = cn;
        @(negedge clk);
        req_valid = 1'b0; req_read = 1'b0; req_write = 1'b0; req_cond = 1'b0;
        got_v = rsp_valid; got_p = rsp_pass; got_w = wake;
    endtask

    task automatic lr(input int ctx, input logic [31:0] a);
        issue(ctx, a, 1'b1, 1'b0, 1'b1);
    endtask

    task automatic sc(input int ctx, input logic [31:0] a, input logic exp_p,
                      input logic [3:0] exp_w, input string tag);
        issue(ctx, a, 1'b0, 1'b1, 1'b1);
        chk({tag, " valid"}, 32'(got_v), 32'd1);
        chk({tag, " pass"}, 32'(got_p), 32'(exp_p));
        chk({tag, " wake"}, 32'(got_w), 32'(exp_w));
    endtask

    task automatic t_reset;
        chk("R1 rsp_valid after reset", 32'(rsp_valid), 32'd0);
        chk("R1 wake after reset", 32'(wake), 32'd0);
        sc(0, 32'h100, 1'b0, 4'b0000, "R1 sc after reset");
    endtask

    task automatic t_basic;
        lr(1, 32'h200);
        sc(1, 32'h204, 1'b1, 4'b0010, "R2 R3 sc same granule");
        sc(1, 32'h200, 1'b0, 4'b0000, "R7 reservation consumed");
    endtask

    task automatic t_replace;
        lr(2, 32'h300);
        lr(2, 32'h400);
        sc(2, 32'h300, 1'b0, 4'b0000, "R4 old granule");
        sc(2, 32'h400, 1'b1, 4'b0100, "R4 new granule");
    endtask

    task automatic t_other_ctx;
        lr(0, 32'h500);
        sc(3, 32'h500, 1'b0, 4'b0000, "R5 foreign reservation");
        sc(0, 32'h500, 1'b1, 4'b0001, "R5 own reservation");
    endtask

    task automatic t_plain_store;
        lr(0, 32'h600); lr(1, 32'h600); lr(2, 32'h600); lr(3, 32'h700);
        issue(3, 32'h603, 1'b0, 1'b1, 1'b0);
        chk("R6 plain store valid", 32'(got_v), 32'd1);
        chk("R6 plain store pass", 32'(got_p), 32'd1);
        chk("R7 plain store wakes all", 32'(got_w), 32'b0111);
        sc(3, 32'h700, 1'b1, 4'b1000, "R10 other granule kept");
        sc(1, 32'h600, 1'b0, 4'b0000, "R7 cleared by plain store");
    endtask

    task automatic t_fail_keeps;
        lr(1, 32'h800); lr(2, 32'h900);
        sc(1, 32'h900, 1'b0, 4'b0000, "R8 failing sc");
        sc(2, 32'h900, 1'b1, 4'b0100, "R8 other kept");
        sc(1, 32'h800, 1'b1, 4'b0010, "R8 own kept");
    endtask

    task automatic t_read_ignored;
        lr(0, 32'hA00);
        issue(0, 32'hB00, 1'b1, 1'b0, 1'b0);
        chk("R9 plain read no response", 32'(got_v), 32'd0);
        sc(0, 32'hA00, 1'b1, 4'b0001, "R9 reservation intact");
        lr(1, 32'hC00);
        issue(2, 32'hC00, 1'b1, 1'b1, 1'b0);
        chk("R9 read+write valid", 32'(got_v), 32'd1);
        chk("R9 read+write pass", 32'(got_p), 32'd1);
        chk("R9 read+write wake", 32'(got_w), 32'b0010);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset;
        t_basic;
        t_replace;
        t_other_ctx;
        t_plain_store;
        t_fail_keeps;
        t_read_ignored;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule